// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Register Block

This block is the host-facing register set of a CAN controller. It holds the mode byte, the status byte, the interrupt-flag byte and the interrupt-enable byte, and it decodes command writes. Single-cycle strobes from the receive FIFO and the transmit path update status and flags: frame arriving, frame stored, frame dropped, overrun and transmit done. The FIFO also supplies its current message count. The block drives a level interrupt line, one-cycle command pulses toward the transmit path and the FIFO, and an enable that tells the receive path whether frames may be taken in.

A byte-wide port with separate read and write strobes reaches the registers. Read data is combinational from the current register values. The only read with a side effect is the interrupt-flag read, which takes effect at the clock edge that ends the read cycle. All other updates also land on the rising clock edge in the cycle of the strobe or write.

Register addresses are mode 0, command 1, status 2, interrupt flags 3, interrupt enable 4, and the first transmit-buffer byte 16 (write only). Status bits are: 0 receive data present, 1 overrun, 2 transmit buffer free, 3 transmit complete, 4 receive active, 5 transmit active. Flag bits are: 0 receive, 1 transmit, 3 overrun. Command bits are: 0 transmit request, 2 release receive buffer, 3 clear overrun.

Top module: `can_stat_irq`

## Requirements
- R1: After reset, the mode register reads 0x01, `status_o` is 0x3C, `irq_flags_o` is 0x00, the enable register reads 0x00, `irq_o` is low and both command pulses are low.
- R2: `irq_o` is high exactly when the bitwise AND of the enable register (address 4) and `irq_flags_o` is nonzero.
- R3: A read of address 3 returns the current flags. At that edge all flags are cleared, except that flag bit 0 is set again when `msg_count_i` is nonzero and events in the same cycle still set their flags.
- R4: A write to address 1 with bit 0 set clears status bits 2 and 3 at that edge and raises `tx_req_o` for exactly the following cycle. Bit 2 raises `rx_release_o` for exactly the following cycle.
- R5: `tx_done_i` sets status bits 2 and 3, clears status bit 5 and sets flag bit 1.
- R6: A write to address 1 with bit 3 set clears status bit 1 and flag bit 3.
- R7: `rx_start_i` sets status bit 4. A stored, dropped or overrun strobe clears it.
- R8: `rx_store_i` sets status bit 0 and flag bit 0. Both bits clear in any cycle where `msg_count_i` is zero and no frame is stored.
- R9: `rx_ovr_i` sets status bit 1 and flag bit 3.
- R10: Writes to addresses 2 and 3 change nothing. Address 1 reads 0x00, addresses other than 0 to 4 read 0xFF, and a mode write keeps only its low five bits.
- R11: A write to address 16 sets status bit 5 only when mode bit 0 is 0. In reset mode it has no effect.
- R12: While mode bit 0 is 1, `rx_enable_o` is low and the start, store, drop and overrun strobes have no effect. Otherwise `rx_enable_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| rx_start_i | input | 1 | A received frame is being processed |
| rx_store_i | input | 1 | Frame stored in the receive FIFO |
| rx_drop_i | input | 1 | Frame rejected or dropped |
| rx_ovr_i | input | 1 | Frame lost because the FIFO is full |
| tx_done_i | input | 1 | Transmission complete |
| msg_count_i | input | CNT_W | Messages currently held in the FIFO |
| status_o | output | 8 | Status byte |
| irq_flags_o | output | 8 | Interrupt-flag byte |
| irq_o | output | 1 | Level interrupt line |
| tx_req_o | output | 1 | One-cycle transmit request |
| rx_release_o | output | 1 | One-cycle receive-buffer release |
| rx_enable_o | output | 1 | Receive path may accept frames |

## Verification
The assertions check the following on every cycle: that transmit-done and overrun strobes land in status and flags on the next cycle, that a transmit pulse is always preceded by a matching command write, that status writes leave the status byte alone, that a receive start is ignored in reset mode, and that an interrupt-flag read clears the upper flags. The bench scenarios are the only place that shows the receive flag coming back after a flag read while messages remain, and the full enable-by-flag sweep that sets the interrupt line. They also show the read map across all 32 addresses and the way the receive bits follow the message count down to zero after a release.

// File: rtl/can_stat_irq_pkg.sv
package can_stat_irq_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam int unsigned A_MODE  = 0;
    localparam int unsigned A_CMD   = 1;
    localparam int unsigned A_STAT  = 2;
    localparam int unsigned A_FLAG  = 3;
    localparam int unsigned A_IEN   = 4;
    localparam int unsigned A_TXB0  = 16;

    localparam int unsigned S_RXBUF  = 0;
    localparam int unsigned S_OVR    = 1;
    localparam int unsigned S_TXFREE = 2;
    localparam int unsigned S_TXCMPL = 3;
    localparam int unsigned S_RXACT  = 4;
    localparam int unsigned S_TXACT  = 5;

    localparam int unsigned F_RX  = 0;
    localparam int unsigned F_TX  = 1;
    localparam int unsigned F_OVR = 3;

    localparam int unsigned C_TX     = 0;
    localparam int unsigned C_REL    = 2;
    localparam int unsigned C_CLROVR = 3;

    localparam logic [BYTE_W-1:0] MODE_RST = 8'h01;
    localparam logic [BYTE_W-1:0] MODE_MSK = 8'h1F;
    localparam logic [BYTE_W-1:0] STAT_RST = 8'h3C;
    localparam logic [BYTE_W-1:0] STAT_MSK = 8'h3F;
    localparam logic [BYTE_W-1:0] FLAG_MSK = 8'h0B;
    localparam logic [BYTE_W-1:0] UNMAPPED = 8'hFF;

    typedef struct packed {
        logic tx_req;
        logic rx_rel;
        logic clr_ovr;
    } cmd_t;

    typedef struct packed {
        logic tx_req;
        logic rx_rel;
    } pulse_t;

    typedef struct packed {
        logic start;
        logic store;
        logic drop;
        logic ovr;
    } rx_ev_t;

    typedef struct packed {
        logic [BYTE_W-1:0] flags;
        logic [BYTE_W-1:0] ien;
    } irq_state_t;

endpackage

// File: rtl/can_stat_irq_cmd.sv
module can_stat_irq_cmd
    import can_stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output cmd_t              cmd_now_o,
    output logic              tx_req_o,
    output logic              rx_rel_o
);

    cmd_t   cmd_now;
    pulse_t pulse_d, pulse_q;

    always_comb begin
        cmd_now         = '0;
        cmd_now.tx_req  = cmd_wr_i & wdata_i[C_TX];
        cmd_now.rx_rel  = cmd_wr_i & wdata_i[C_REL];
        cmd_now.clr_ovr = cmd_wr_i & wdata_i[C_CLROVR];
        pulse_d         = '0;
        pulse_d.tx_req  = cmd_now.tx_req;
        pulse_d.rx_rel  = cmd_now.rx_rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign cmd_now_o = cmd_now;
    assign tx_req_o  = pulse_q.tx_req;
    assign rx_rel_o  = pulse_q.rx_rel;

endmodule

// File: rtl/can_stat_irq_status.sv
module can_stat_irq_status
    import can_stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rx_ev_t            rx_ev_i,
    input  logic              tx_done_i,
    input  logic              tx_cmd_i,
    input  logic              clr_ovr_i,
    input  logic              txb0_wr_i,
    input  logic              msg_nz_i,
    output logic [BYTE_W-1:0] status_o
);

    logic [BYTE_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        // receive data present follows the FIFO, a store wins
        if (!msg_nz_i)     stat_d[S_RXBUF] = 1'b0;
        if (rx_ev_i.store) stat_d[S_RXBUF] = 1'b1;
        // overrun: clear command loses to a new overrun
        if (clr_ovr_i)     stat_d[S_OVR] = 1'b0;
        if (rx_ev_i.ovr)   stat_d[S_OVR] = 1'b1;
        // transmit buffer: request empties, completion refills
        if (tx_cmd_i) begin
            stat_d[S_TXFREE] = 1'b0;
            stat_d[S_TXCMPL] = 1'b0;
        end
        if (tx_done_i) begin
            stat_d[S_TXFREE] = 1'b1;
            stat_d[S_TXCMPL] = 1'b1;
        end
        if (txb0_wr_i)     stat_d[S_TXACT] = 1'b1;
        if (tx_done_i)     stat_d[S_TXACT] = 1'b0;
        // receive activity window
        if (rx_ev_i.start) stat_d[S_RXACT] = 1'b1;
        if (rx_ev_i.store || rx_ev_i.drop || rx_ev_i.ovr)
            stat_d[S_RXACT] = 1'b0;
        stat_d = stat_d & STAT_MSK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= STAT_RST;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;

endmodule

// File: rtl/can_stat_irq_flags.sv
module can_stat_irq_flags
    import can_stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              flag_rd_i,
    input  logic              store_i,
    input  logic              ovr_i,
    input  logic              tx_done_i,
    input  logic              clr_ovr_i,
    input  logic              msg_nz_i,
    output logic [BYTE_W-1:0] flags_o,
    output logic [BYTE_W-1:0] ien_o,
    output logic              irq_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_rd_i) begin
            st_d.flags       = '0;
            st_d.flags[F_RX] = msg_nz_i;
        end else if (!msg_nz_i) begin
            st_d.flags[F_RX] = 1'b0;
        end
        if (clr_ovr_i) st_d.flags[F_OVR] = 1'b0;
        if (store_i)   st_d.flags[F_RX]  = 1'b1;
        if (tx_done_i) st_d.flags[F_TX]  = 1'b1;
        if (ovr_i)     st_d.flags[F_OVR] = 1'b1;
        st_d.flags = st_d.flags & FLAG_MSK;
        if (ien_wr_i)  st_d.ien = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign ien_o   = st_q.ien;
    assign irq_o   = |(st_q.flags & st_q.ien);

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
    import can_stat_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              rx_start_i,
    input  logic              rx_store_i,
    input  logic              rx_drop_i,
    input  logic              rx_ovr_i,
    input  logic              tx_done_i,
    input  logic [CNT_W-1:0]  msg_count_i,
    output logic [7:0]        status_o,
    output logic [7:0]        irq_flags_o,
    output logic              irq_o,
    output logic              tx_req_o,
    output logic              rx_release_o,
    output logic              rx_enable_o
);

    localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
    localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_TXB0 = ADDR_W'(A_TXB0);

    logic [BYTE_W-1:0] mode_d, mode_q;
    logic [BYTE_W-1:0] flags, ien, status;
    logic              op_mode, msg_nz;
    rx_ev_t            rx_ev;
    cmd_t              cmd_now;

    assign op_mode = ~mode_q[0];
    assign msg_nz  = |msg_count_i;

    always_comb begin
        rx_ev       = '0;
        rx_ev.start = rx_start_i & op_mode;
        rx_ev.store = rx_store_i & op_mode;
        rx_ev.drop  = rx_drop_i  & op_mode;
        rx_ev.ovr   = rx_ovr_i   & op_mode;
    end

    always_comb begin
        mode_d = mode_q;
        if (reg_wr_i && reg_addr_i == AD_MODE) mode_d = reg_wdata_i & MODE_MSK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RST;
        else        mode_q <= mode_d;
    end

    can_stat_irq_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (reg_wr_i && reg_addr_i == AD_CMD),
        .wdata_i   (reg_wdata_i),
        .cmd_now_o (cmd_now),
        .tx_req_o  (tx_req_o),
        .rx_rel_o  (rx_release_o)
    );

    can_stat_irq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ev_i   (rx_ev),
        .tx_done_i (tx_done_i),
        .tx_cmd_i  (cmd_now.tx_req),
        .clr_ovr_i (cmd_now.clr_ovr),
        .txb0_wr_i (reg_wr_i && reg_addr_i == AD_TXB0 && op_mode),
        .msg_nz_i  (msg_nz),
        .status_o  (status)
    );

    can_stat_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_wr_i  (reg_wr_i && reg_addr_i == AD_IEN),
        .wdata_i   (reg_wdata_i),
        .flag_rd_i (reg_rd_i && reg_addr_i == AD_FLAG),
        .store_i   (rx_ev.store),
        .ovr_i     (rx_ev.ovr),
        .tx_done_i (tx_done_i),
        .clr_ovr_i (cmd_now.clr_ovr),
        .msg_nz_i  (msg_nz),
        .flags_o   (flags),
        .ien_o     (ien),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (reg_addr_i)
            AD_MODE: reg_rdata_o = mode_q;
            AD_CMD:  reg_rdata_o = '0;
            AD_STAT: reg_rdata_o = status;
            AD_FLAG: reg_rdata_o = flags;
            AD_IEN:  reg_rdata_o = ien;
            default: reg_rdata_o = UNMAPPED;
        endcase
    end

    assign status_o    = status;
    assign irq_flags_o = flags;
    assign rx_enable_o = op_mode;

endmodule

// File: rtl/can_stat_irq_chk.sv
module can_stat_irq_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [7:0]        reg_wdata_i,
    input logic              rx_start_i,
    input logic              rx_store_i,
    input logic              rx_drop_i,
    input logic              rx_ovr_i,
    input logic              tx_done_i,
    input logic [7:0]        status_o,
    input logic [7:0]        irq_flags_o,
    input logic              irq_o,
    input logic              tx_req_o,
    input logic              rx_enable_o
);

    // R5
    tx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> status_o[2] && status_o[3] && !status_o[5] && irq_flags_o[1]);

    // R9
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr_i && rx_enable_o) |=> status_o[1] && irq_flags_o[3]);

    // R4
    tx_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req_o) |-> $past(reg_wr_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[0]));

    // R10
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(2) && !rx_start_i && !rx_store_i &&
         !rx_drop_i && !rx_ovr_i && !tx_done_i) |=> status_o[7:1] == $past(status_o[7:1]));

    // R12
    reset_mode_rx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable_o && rx_start_i && !status_o[4] && !reg_wr_i) |=> !status_o[4]);

    // R3
    flag_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(3) && !tx_done_i && !rx_ovr_i)
        |=> irq_flags_o[3:1] == 3'b000);

    // R2
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_flags_o != 8'h00);

endmodule

bind can_stat_irq can_stat_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .rx_start_i  (rx_start_i),
    .rx_store_i  (rx_store_i),
    .rx_drop_i   (rx_drop_i),
    .rx_ovr_i    (rx_ovr_i),
    .tx_done_i   (tx_done_i),
    .status_o    (status_o),
    .irq_flags_o (irq_flags_o),
    .irq_o       (irq_o),
    .tx_req_o    (tx_req_o),
    .rx_enable_o (rx_enable_o)
);

// File: tb/can_stat_irq_tb_top.sv
module can_stat_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              rx_start = 1'b0, rx_store = 1'b0, rx_drop = 1'b0, rx_ovr = 1'b0;
    logic              tx_done = 1'b0;
    logic [CNT_W-1:0]  msg_count = '0;
    logic [7:0]        status, flags;
    logic              irq, tx_req, rx_rel, rx_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_stat_irq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .rx_start_i(rx_start), .rx_store_i(rx_store), .rx_drop_i(rx_drop),
        .rx_ovr_i(rx_ovr), .tx_done_i(tx_done), .msg_count_i(msg_count),
        .status_o(status), .irq_flags_o(flags), .irq_o(irq),
        .tx_req_o(tx_req), .rx_release_o(rx_rel), .rx_enable_o(rx_en)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // strobe bits: 0 start, 1 store, 2 drop, 3 overrun, 4 tx done
    task automatic ev(input logic [4:0] s);
        @(negedge clk);
        {tx_done, rx_ovr, rx_drop, rx_store, rx_start} = s;
        @(negedge clk);
        {tx_done, rx_ovr, rx_drop, rx_store, rx_start} = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v);             chk("R1 mode", v, 8'h01);
        rd(4, v);             chk("R1 enable", v, 8'h00);
        chk("R1 status", status, 8'h3C);
        chk("R1 flags", flags, 8'h00);
        chk("R1 irq/pulses", {5'b0, irq, tx_req, rx_rel}, 8'h00);
        chk("R12 rx_enable in reset mode", {7'b0, rx_en}, 8'h00);

        // R12 receive strobes ignored in reset mode
        msg_count = CNT_W'(1);
        ev(5'b01010);         chk("R12 status after ignored rx", status, 8'h3D & 8'h3C);
        chk("R12 flags after ignored rx", flags, 8'h00);
        msg_count = '0;
        ev(5'b00100);         chk("R12 drop ignored", status, 8'h3C);

        // R11 transmit byte write in reset mode: first clear bit 5 via tx done
        ev(5'b10000);         chk("R5 tx done", status, 8'h1C);
        chk("R5 tx flag", flags, 8'h02);
        wr(16, 8'h55);        chk("R11 txb0 in reset mode", status, 8'h1C);

        // R10 mode mask, enter operating mode
        wr(0, 8'hFE);
        rd(0, v);             chk("R10 mode mask", v, 8'h1E);
        chk("R12 rx_enable operating", {7'b0, rx_en}, 8'h01);
        rd(3, v);             chk("R3 read returns tx flag", v, 8'h02);
        chk("R3 flags cleared", flags, 8'h00);

        // R10 address sweep
        for (int a = 0; a < 32; a++) begin
            logic [7:0] e;
            case (a)
                0: e = 8'h1E;
                1: e = 8'h00;
                2: e = 8'h1C;
                3: e = 8'h00;
                4: e = 8'h00;
                default: e = 8'hFF;
            endcase
            rd(a, v);
            chk($sformatf("R10 read addr %0d", a), v, e);
        end

        // R10 writes to status and flags ignored
        wr(2, 8'h00);         chk("R10 status write", status, 8'h1C);
        wr(3, 8'hFF);         chk("R10 flag write", flags, 8'h00);

        // R7 receive activity
        ev(5'b00001);         chk("R7 start", status, 8'h1C);
        ev(5'b00100);         chk("R7 drop clears", status, 8'h0C);
        ev(5'b00001);         chk("R7 start sets", status, 8'h1C);

        // R8 store with one message
        msg_count = CNT_W'(1);
        ev(5'b00010);         chk("R8 store status", status, 8'h0D);
        chk("R8 store flag", flags, 8'h01);

        // R3 read with messages left re-asserts flag 0
        rd(3, v);             chk("R3 read value", v, 8'h01);
        chk("R3 rx flag re-asserted", flags, 8'h01);

        // R11 transmit byte in operating mode
        wr(16, 8'hA5);        chk("R11 txb0 sets bit5", status, 8'h2D);

        // R4 transmit request
        wr(1, 8'h01);         chk("R4 status after request", status, 8'h21);
        chk("R4 tx_req high", {7'b0, tx_req}, 8'h01);
        @(negedge clk);       chk("R4 tx_req low", {7'b0, tx_req}, 8'h00);
        ev(5'b10000);         chk("R5 tx done status", status, 8'h0D);
        chk("R5 tx done flag", flags, 8'h03);

        // R9 overrun
        ev(5'b01000);         chk("R9 overrun status", status, 8'h0F);
        chk("R9 overrun flag", flags, 8'h0B);

        // R2 enable sweep against flags 0x0B
        for (int e = 0; e < 256; e++) begin
            wr(4, 8'(e));
            chk($sformatf("R2 irq en=%02h", e), {7'b0, irq}, {7'b0, |(8'(e) & 8'h0B)});
        end

        // R3 read clears all but re-asserted rx flag
        rd(3, v);             chk("R3 read 0x0B", v, 8'h0B);
        chk("R3 flags after read", flags, 8'h01);
        chk("R2 irq still high", {7'b0, irq}, 8'h01);

        // R6 clear overrun
        ev(5'b01000);         chk("R9 overrun again", flags, 8'h09);
        wr(1, 8'h08);         chk("R6 status overrun cleared", status, 8'h0D);
        chk("R6 flag overrun cleared", flags, 8'h01);

        // R4 release and R8 follow count to zero
        wr(1, 8'h04);         chk("R4 release pulse", {7'b0, rx_rel}, 8'h01);
        msg_count = '0;
        @(negedge clk);       chk("R4 release pulse ends", {7'b0, rx_rel}, 8'h00);
        chk("R8 status rx cleared", status, 8'h0C);
        chk("R8 flag rx cleared", flags, 8'h00);
        chk("R2 irq low", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule